// File: doc/BRIEF.md
# Self-Clearing Frame Init Pulse Generator

This block produces an initialisation strobe for a secondary frame-timing counter. A register write carries a 2-bit alignment-mode field and an init bit that triggers on a write of one. The strobe is armed only when the same write leaves the mode field at the one-shot manual value. When that happens, the init output goes high combinationally, in the same clock cycle as the write. It does not wait for any line sync.

The output then stays high until the timing signals release it. The first frame strobe after the trigger is seen first. After it, a parameterised number of line strobes must pass (one by default), and then the output drops. The init bit is self-clearing and always reads back as zero. The mode field reads back the value last written.

The sync inputs are single-cycle strobes by default. A parameter switches each sync input to a level input, which then passes through a rising-edge detector. All pins are plain control and status signals. No data stream crosses the block, so there is no valid/ready handshake.

Top module: `frame_init_strobe`

## Requirements
- R1: After reset the mode readback is 2'b11 (never align), and the init output is low.
- R2: A cycle with `cfg_wr` high loads `cfg_mode_in` into the mode field. The new value is visible on `cfg_mode_rd` in the following cycle.
- R3: `cfg_init_rd` reads zero in every cycle, including the cycle of a write with the init bit set.
- R4: A write with the init bit set triggers only when the mode written is 2'b01 (one-shot manual). Writes with mode 2'b00, 2'b10 or 2'b11 leave the init output low. A write with mode 2'b01 and the init bit clear also leaves it low.
- R5: An accepted trigger raises `init_out` in the same cycle as the write, whether or not a line strobe is present.
- R6: Once raised, `init_out` stays high, whatever line strobes arrive, until the first frame strobe after the trigger cycle.
- R7: After that frame strobe, `init_out` falls in the cycle after the TAIL_LINES-th line strobe (default 1). A line strobe in the same cycle as the frame strobe is not counted.
- R8: A trigger written while `init_out` is already high is ignored. It neither restarts the frame wait nor extends the pulse.
- R9: A frame or line strobe in the trigger cycle itself does not advance the release sequence.
- R10: Once `init_out` has fallen, a new accepted trigger raises it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_mode_in | input | 2 | Alignment mode written (00 auto, 01 one-shot manual, 10 always, 11 never) |
| cfg_init_in | input | 1 | Init trigger bit written |
| vframe_in | input | 1 | Frame sync (strobe, or level if VS_LEVEL=1) |
| hline_in | input | 1 | Line sync (strobe, or level if HS_LEVEL=1) |
| cfg_mode_rd | output | 2 | Mode field readback |
| cfg_init_rd | output | 1 | Init bit readback, always zero |
| init_out | output | 1 | Init pulse to the downstream frame counter |

## Verification
Some behaviours are checked by assertions on every cycle:
- an accepted trigger drives the output high in that same cycle;
- the pulse never falls without a line strobe in the cycle before;
- while the block is waiting for the frame strobe, the output cannot drop;
- a rejected write never starts a pulse;
- the mode field always follows the last write.

Other behaviours are shown only by the bench scenarios:
- the exact release cycle after the frame strobe;
- that strobes arriving together with the trigger, or together with the frame strobe, are discounted;
- that re-triggering during a pulse leaves its end unchanged;
- the reset state.

// File: rtl/fis_pkg.sv
package fis_pkg;
  typedef enum logic [1:0] {
    ALIGN_AUTO    = 2'b00,
    ALIGN_ONESHOT = 2'b01,
    ALIGN_ALWAYS  = 2'b10,
    ALIGN_NEVER   = 2'b11
  } align_mode_e;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'b00,
    PS_FRAME = 2'b01,
    PS_TAIL  = 2'b10
  } pulse_state_e;

  localparam align_mode_e MODE_RESET = ALIGN_NEVER;
endpackage

// File: rtl/fis_sync_cond.sv
module fis_sync_cond #(
  parameter bit LEVEL_IN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic strb_out
);
  generate
    if (LEVEL_IN) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= raw_in;
      end
      assign strb_out = raw_in & ~prev_q;
    end else begin : g_pass
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign strb_out = raw_in;
    end
  endgenerate
endmodule

// File: rtl/fis_ctrl_reg.sv
module fis_ctrl_reg
  import fis_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_mode,
  input  logic        wr_init,
  input  logic        busy,
  output align_mode_e mode_q,
  output logic        trig
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= MODE_RESET;
    else if (wr_en) mode_q <= align_mode_e'(wr_mode);
  end

  // The trigger is qualified by the mode carried in the same write, not the stored one.
  assign trig = wr_en & wr_init & (wr_mode == ALIGN_ONESHOT) & ~busy;

  assert_mode_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mode_q == align_mode_e'($past(wr_mode))));

  assert_wrong_mode_no_trig_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_mode != ALIGN_ONESHOT)) |-> !trig);
endmodule

// File: rtl/fis_pulse_fsm.sv
module fis_pulse_fsm
  import fis_pkg::*;
#(
  parameter int TAIL_LINES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic vs_strb,
  input  logic hs_strb,
  output logic busy
);
  localparam int CW = (TAIL_LINES > 1) ? $clog2(TAIL_LINES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TAIL_LINES - 1);

  pulse_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      PS_IDLE: if (trig) begin
        st_d  = PS_FRAME;
        cnt_d = '0;
      end
      PS_FRAME: if (vs_strb) begin
        st_d  = PS_TAIL;
        cnt_d = '0;
      end
      PS_TAIL: if (hs_strb) begin
        if (cnt_q == LAST) st_d = PS_IDLE;
        else               cnt_d = cnt_q + 1'b1;
      end
      default: st_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy = (st_q != PS_IDLE);

  assert_hold_until_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_FRAME && !vs_strb) |=> busy);

  assert_release_on_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(hs_strb));

  assert_retrigger_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig) |-> 1'b0);
endmodule

// File: rtl/frame_init_strobe.sv
module frame_init_strobe
  import fis_pkg::*;
#(
  parameter int TAIL_LINES = 1,
  parameter bit VS_LEVEL   = 1'b0,
  parameter bit HS_LEVEL   = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_mode_in,
  input  logic       cfg_init_in,
  input  logic       vframe_in,
  input  logic       hline_in,
  output logic [1:0] cfg_mode_rd,
  output logic       cfg_init_rd,
  output logic       init_out
);
  logic vs_strb, hs_strb, trig, busy;
  align_mode_e mode_q;

  fis_sync_cond #(.LEVEL_IN(VS_LEVEL)) u_vs (
    .clk(clk), .rst_n(rst_n), .raw_in(vframe_in), .strb_out(vs_strb));
  fis_sync_cond #(.LEVEL_IN(HS_LEVEL)) u_hs (
    .clk(clk), .rst_n(rst_n), .raw_in(hline_in), .strb_out(hs_strb));

  fis_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_mode(cfg_mode_in),
    .wr_init(cfg_init_in), .busy(busy), .mode_q(mode_q), .trig(trig));

  fis_pulse_fsm #(.TAIL_LINES(TAIL_LINES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .trig(trig), .vs_strb(vs_strb),
    .hs_strb(hs_strb), .busy(busy));

  assign cfg_mode_rd = mode_q;
  assign cfg_init_rd = 1'b0;
  assign init_out    = busy | trig;

  assert_immediate_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> init_out);

  assert_rejected_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_out && cfg_wr && cfg_init_in && cfg_mode_in != 2'b01) |=> !init_out);
endmodule

// File: tb/sim_frame_init_strobe.sv
module sim_frame_init_strobe;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, cfg_init_in = 0, vframe_in = 0, hline_in = 0;
  logic [1:0] cfg_mode_in = 0;
  logic [1:0] cfg_mode_rd;
  logic cfg_init_rd, init_out;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  frame_init_strobe u0 (.*);

  // {mode[1:0], init bit, expect pulse}
  localparam logic [3:0] VEC [7] = '{
    4'b01_1_1, 4'b11_1_0, 4'b00_1_0, 4'b10_1_0, 4'b01_0_0, 4'b01_1_1, 4'b11_0_0};

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive a write at negedge; sample outputs 1 ns later (same cycle)
  task automatic wr(input logic [1:0] m, input logic b, input logic vs, input logic hs);
    @(negedge clk);
    cfg_wr = 1; cfg_mode_in = m; cfg_init_in = b; vframe_in = vs; hline_in = hs;
    #1;
  endtask

  task automatic idle_cyc();
    @(negedge clk);
    cfg_wr = 0; cfg_init_in = 0; vframe_in = 0; hline_in = 0;
    #1;
  endtask

  task automatic strobe(input logic vs, input logic hs);
    @(negedge clk);
    cfg_wr = 0; cfg_init_in = 0; vframe_in = vs; hline_in = hs;
    #1;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mode reset", cfg_mode_rd, 2'b11);
    chk("R1 init reset", {1'b0, init_out}, 0);
    rst_n = 1;
    idle_cyc();
    chk("R1 mode after reset", cfg_mode_rd, 2'b11);

    foreach (VEC[i]) begin
      wr(VEC[i][3:2], VEC[i][1], 0, 0);
      chk("R4/R5 same-cycle init", {1'b0, init_out}, {1'b0, VEC[i][0]});
      chk("R3 init readback", {1'b0, cfg_init_rd}, 0);
      idle_cyc();
      chk("R2 mode readback", cfg_mode_rd, VEC[i][3:2]);
      chk("R4 pulse held", {1'b0, init_out}, {1'b0, VEC[i][0]});
      if (VEC[i][0]) begin
        strobe(1, 0);
        chk("R6 high at frame", {1'b0, init_out}, 1);
        strobe(0, 1);
        chk("R7 high at line", {1'b0, init_out}, 1);
        idle_cyc();
        chk("R7 released", {1'b0, init_out}, 0);
      end
    end

    // R6: line strobes before the frame strobe do not release
    wr(2'b01, 1, 0, 1);
    chk("R5 rise with line strobe", {1'b0, init_out}, 1);
    for (int k = 0; k < 4; k++) begin
      strobe(0, 1);
      chk("R6 line before frame", {1'b0, init_out}, 1);
    end
    // R8: re-trigger while busy is ignored
    wr(2'b01, 1, 0, 0);
    chk("R3 readback during pulse", {1'b0, cfg_init_rd}, 0);
    // R7: line coincident with frame not counted
    strobe(1, 1);
    idle_cyc();
    chk("R7 coincident line not counted", {1'b0, init_out}, 1);
    strobe(0, 1);
    idle_cyc();
    chk("R8 retrigger did not extend", {1'b0, init_out}, 0);

    // R9: frame and line strobes in the trigger cycle are not counted
    wr(2'b01, 1, 1, 1);
    chk("R10 retrigger after release", {1'b0, init_out}, 1);
    strobe(0, 1);
    idle_cyc();
    chk("R9 trigger-cycle frame ignored", {1'b0, init_out}, 1);
    strobe(1, 0);
    strobe(0, 1);
    idle_cyc();
    chk("R9 released after real sequence", {1'b0, init_out}, 0);

    // R4: write of mode 11 during idle leaves output low, readback updates
    wr(2'b11, 1, 0, 0);
    chk("R4 never-align write", {1'b0, init_out}, 0);
    idle_cyc();
    chk("R2 mode 11 readback", cfg_mode_rd, 2'b11);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule